// File: doc/BRIEF.md
# Prioritized Queue-to-Channel Transmit Arbiter

This block picks which of sixteen transmit queues is served next and steers that queue's request to one of eight prioritized DMA channels. Software binds each queue to exactly one channel through a small write port. Several queues may share a channel. The channels are fixed traffic classes: background (0), best effort (1), video (2), voice and management (3), three spare channels (4 to 6) and the command channel (7).

Each cycle the arbiter looks at the queues that are enabled and pending. It groups them by channel and drops every channel whose busy input is high. It then grants the highest-numbered channel that remains. Inside that channel, a per-channel round-robin pointer decides which queue wins. The grant is registered and lasts one cycle: a one-hot channel strobe, plus the winning queue index in that channel's slot of a packed index bus.

Top module: `txq_chan_arbiter`

## Requirements
- R1: A queue is granted only on the channel given by its 3-bit map entry, and a queue with a map entry that names a channel is granted on that channel and on no other.
- R2: Reset clears all grant outputs to zero and disables every queue. It maps queues 0 to 6 to channels 0 to 6 and maps queues 7 to 15 to channel 0.
- R3: When `cfg_we` is high at a rising edge, queue `cfg_qid` takes `cfg_en` as its enable and `cfg_chan` as its map entry. The new values govern selection from the next rising edge on.
- R4: Queues 7 to 15 accept only channels 0 to 3. A write with `cfg_chan` of 4 or more to one of these queues leaves its map entry unchanged, but still updates its enable.
- R5: A queue that is disabled, or whose `q_pend` bit is low, is never granted.
- R6: A channel whose `ch_busy` bit is high at an edge receives no grant from that edge. The grant instead goes to the best remaining channel.
- R7: Among channels with an eligible queue and no busy, the highest channel number wins. This puts command (7) above everything and orders the data classes voice (3) > video (2) > best effort (1) > background (0).
- R8: At most one channel is granted per cycle, so `gnt_vld` is zero or one-hot. A grant reflects the inputs at the preceding rising edge and lasts exactly one cycle.
- R9: Within a channel, the queue granted last has the lowest priority on the next pick. The search runs upward from the last served queue and wraps at 15, and after reset it starts at queue 0.
- R10: The granted queue index appears in bits 4c+3..4c of `gnt_qid` for granted channel c, and all other bits of `gnt_qid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_qid | input | 4 | Queue written |
| cfg_chan | input | 3 | Channel map value written |
| cfg_en | input | 1 | Enable value written |
| q_pend | input | 16 | Per-queue pending frame flag |
| ch_busy | input | 8 | Per-channel backpressure |
| gnt_vld | output | 8 | Per-channel grant strobe |
| gnt_qid | output | 32 | Per-channel granted queue index, 4 bits per channel |

## Verification
The hardest state to reach is a channel with many queues whose round-robin pointer sits in the middle of the queue range. When that happens, the wrap from queue 15 back to low queues matters, and so does the interplay with a busy channel that holds its pointer frozen. The stimulus builds this state by remapping queue 3 and all high queues onto one channel and stepping many grants through it while pending bits drop out. It also sweeps all 256 busy patterns with every queue pending, so the pointers of every channel advance in many different interleavings.

// File: rtl/txarb_pkg.sv
package txarb_pkg;
    localparam int NQ_DEF      = 16;
    localparam int NCH_DEF     = 8;
    localparam int NDIRECT_DEF = 7;  // queues that may use any channel
    localparam int NLOW_DEF    = 4;  // channels open to the other queues

    function automatic int reset_chan(input int q, input int ndirect);
        return (q < ndirect) ? q : 0;
    endfunction
endpackage

// File: rtl/txarb_qcfg.sv
module txarb_qcfg #(
    parameter int NQ      = txarb_pkg::NQ_DEF,
    parameter int NCH     = txarb_pkg::NCH_DEF,
    parameter int NDIRECT = txarb_pkg::NDIRECT_DEF,
    parameter int NLOW    = txarb_pkg::NLOW_DEF,
    localparam int QW = $clog2(NQ),
    localparam int CW = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic [QW-1:0]    wr_q,
    input  logic [CW-1:0]    wr_chan,
    input  logic             wr_en,
    output logic [NQ*CW-1:0] map_flat,
    output logic [NQ-1:0]    q_on
);
    logic [CW-1:0] map_r [NQ];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int q = 0; q < NQ; q++) begin
                map_r[q] <= CW'(txarb_pkg::reset_chan(q, NDIRECT));
            end
            q_on <= '0;
        end else if (wr_stb) begin
            q_on[wr_q] <= wr_en;
            if (int'(wr_q) < NDIRECT || int'(wr_chan) < NLOW) begin
                map_r[wr_q] <= wr_chan;
            end
        end
    end

    for (genvar q = 0; q < NQ; q++) begin : g_flat
        assign map_flat[q*CW +: CW] = map_r[q];
        if (q >= NDIRECT) begin : g_chk
            AST_HIGH_Q_LOW_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
                int'(map_r[q]) < NLOW); // R4
        end
    end
endmodule

// File: rtl/txarb_rr_pick.sv
module txarb_rr_pick #(
    parameter int NQ  = txarb_pkg::NQ_DEF,
    parameter int NCH = txarb_pkg::NCH_DEF,
    parameter int CH  = 0,
    localparam int QW = $clog2(NQ),
    localparam int CW = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NQ*CW-1:0] map_flat,
    input  logic [NQ-1:0]    elig,
    input  logic             served,
    output logic             req_any,
    output logic [QW-1:0]    pick_q
);
    logic [NQ-1:0] hit;
    logic [QW-1:0] last_q;

    for (genvar q = 0; q < NQ; q++) begin : g_hit
        assign hit[q] = elig[q] && (map_flat[q*CW +: CW] == CW'(CH));
    end

    always_comb begin
        req_any = 1'b0;
        pick_q  = '0;
        for (int i = 1; i <= NQ; i++) begin
            int idx;
            idx = (int'(last_q) + i) % NQ;
            if (!req_any && hit[idx]) begin
                req_any = 1'b1;
                pick_q  = QW'(idx);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      last_q <= QW'(NQ - 1);
        else if (served) last_q <= pick_q;
    end

    AST_PICK_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_any |-> elig[pick_q]); // R5
    AST_PICK_MAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        req_any |-> (map_flat[pick_q*CW +: CW] == CW'(CH))); // R1
    AST_SERVE_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        served |-> req_any); // R9
endmodule

// File: rtl/txarb_prio_sel.sv
module txarb_prio_sel #(
    parameter int NCH = txarb_pkg::NCH_DEF,
    localparam int CW = $clog2(NCH)
) (
    input  logic [NCH-1:0] req,
    input  logic [NCH-1:0] busy,
    output logic           sel_vld,
    output logic [CW-1:0]  sel_ch
);
    always_comb begin
        sel_vld = 1'b0;
        sel_ch  = '0;
        for (int c = 0; c < NCH; c++) begin
            if (req[c] && !busy[c]) begin
                sel_vld = 1'b1;
                sel_ch  = CW'(c);
            end
        end
    end
endmodule

// File: rtl/txq_chan_arbiter.sv
module txq_chan_arbiter #(
    parameter int NQ      = txarb_pkg::NQ_DEF,
    parameter int NCH     = txarb_pkg::NCH_DEF,
    parameter int NDIRECT = txarb_pkg::NDIRECT_DEF,
    parameter int NLOW    = txarb_pkg::NLOW_DEF,
    localparam int QW = $clog2(NQ),
    localparam int CW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [QW-1:0]     cfg_qid,
    input  logic [CW-1:0]     cfg_chan,
    input  logic              cfg_en,
    input  logic [NQ-1:0]     q_pend,
    input  logic [NCH-1:0]    ch_busy,
    output logic [NCH-1:0]    gnt_vld,
    output logic [NCH*QW-1:0] gnt_qid
);
    logic [NQ*CW-1:0] map_flat;
    logic [NQ-1:0]    q_on;
    logic [NQ-1:0]    elig;
    logic [NCH-1:0]   ch_req;
    logic [QW-1:0]    ch_pick [NCH];
    logic [NCH-1:0]   served;
    logic             sel_vld;
    logic [CW-1:0]    sel_ch;

    txarb_qcfg #(.NQ(NQ), .NCH(NCH), .NDIRECT(NDIRECT), .NLOW(NLOW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_stb(cfg_we), .wr_q(cfg_qid),
        .wr_chan(cfg_chan), .wr_en(cfg_en), .map_flat(map_flat), .q_on(q_on)
    );

    assign elig = q_on & q_pend;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign served[c] = sel_vld && (sel_ch == CW'(c));
        txarb_rr_pick #(.NQ(NQ), .NCH(NCH), .CH(c)) u_rr (
            .clk(clk), .rst_n(rst_n), .map_flat(map_flat), .elig(elig),
            .served(served[c]), .req_any(ch_req[c]), .pick_q(ch_pick[c])
        );
        AST_NO_BUSY_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_vld[c] |-> $past(!ch_busy[c])); // R6
        AST_IDLE_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !gnt_vld[c] |-> (gnt_qid[c*QW +: QW] == '0)); // R10
    end

    txarb_prio_sel #(.NCH(NCH)) u_sel (
        .req(ch_req), .busy(ch_busy), .sel_vld(sel_vld), .sel_ch(sel_ch)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gnt_vld <= '0;
            gnt_qid <= '0;
        end else begin
            gnt_vld <= served;
            gnt_qid <= '0;
            if (sel_vld) gnt_qid[sel_ch*QW +: QW] <= ch_pick[sel_ch];
        end
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_vld)); // R8
    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt_vld) |-> $past(|(ch_req & ~ch_busy))); // R7
endmodule

// File: tb/sim_txq_chan_arbiter.sv
module sim_txq_chan_arbiter;
    localparam int NQ = 16;
    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_qid = '0;
    logic [2:0]  cfg_chan = '0;
    logic        cfg_en = 1'b0;
    logic [15:0] q_pend = '0;
    logic [7:0]  ch_busy = '0;
    logic [7:0]  gnt_vld;
    logic [31:0] gnt_qid;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    int m_map [NQ];
    bit m_en  [NQ];
    int m_ptr [NCH];

    always #5 clk = ~clk;

    txq_chan_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_qid(cfg_qid),
        .cfg_chan(cfg_chan), .cfg_en(cfg_en), .q_pend(q_pend),
        .ch_busy(ch_busy), .gnt_vld(gnt_vld), .gnt_qid(gnt_qid)
    );

    task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model computed from the requirements, then one clock.
    task automatic step(input string tag);
        logic [7:0]  ev = '0;
        logic [31:0] eq = '0;
        int best_c = -1;
        int best_q = 0;
        for (int c = 0; c < NCH; c++) begin
            if (!ch_busy[c]) begin
                for (int i = 1; i <= NQ; i++) begin
                    int q;
                    q = (m_ptr[c] + i) % NQ;
                    if (m_en[q] && q_pend[q] && m_map[q] == c) begin
                        best_c = c;
                        best_q = q;
                        break;
                    end
                end
            end
        end
        if (best_c >= 0) begin
            ev[best_c] = 1'b1;
            eq[best_c*4 +: 4] = 4'(best_q);
            m_ptr[best_c] = best_q;
        end
        if (cfg_we) begin
            m_en[cfg_qid] = cfg_en;
            if (cfg_qid < 7 || cfg_chan < 4) m_map[cfg_qid] = int'(cfg_chan);
        end
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        check(tag, {gnt_vld, gnt_qid}, {ev, eq});
    endtask

    task automatic wr(input int q, input int ch, input bit en, input string tag);
        cfg_we = 1'b1;
        cfg_qid = 4'(q);
        cfg_chan = 3'(ch);
        cfg_en = en;
        step(tag);
    endtask

    initial begin
        for (int q = 0; q < NQ; q++) begin
            m_map[q] = (q < 7) ? q : 0;
            m_en[q] = 1'b0;
        end
        for (int c = 0; c < NCH; c++) m_ptr[c] = NQ - 1;
        repeat (3) @(negedge clk);
        check("R2 reset outputs", {gnt_vld, gnt_qid}, 40'h0);
        rst_n = 1'b1;
        q_pend = 16'hFFFF;
        // R2/R5: nothing enabled after reset, nothing granted
        for (int i = 0; i < 3; i++) step("R5 disabled after reset");
        // R3: enable queues one by one with the reset map
        for (int q = 0; q < NQ; q++) wr(q, (q < 7) ? q : 0, 1'b1, "R3 enable write");
        // R1: one queue pending at a time
        for (int q = 0; q < NQ; q++) begin
            q_pend = 16'(1 << q);
            step("R1 single queue");
            step("R1 single queue repeat");
        end
        // R6/R7: sweep all busy patterns with everything pending
        q_pend = 16'hFFFF;
        for (int b = 0; b < 256; b++) begin
            ch_busy = 8'(b);
            step("R6 R7 busy sweep");
        end
        ch_busy = '0;
        // R5: pending but disabled queues
        for (int q = 4; q < 7; q++) wr(q, q, 1'b0, "R5 disable");
        for (int i = 0; i < 6; i++) step("R5 disabled skipped");
        // R4: high queue rejects channel 7, keeps channel 0, enable still taken
        wr(9, 7, 1'b0, "R4 rejected map");
        q_pend = 16'(1 << 9);
        step("R4 disabled by same write");
        wr(9, 7, 1'b1, "R4 rejected map enable");
        step("R4 stays on channel 0");
        // R9: queue 3 and high queues share channel 3, rotation with wrap
        for (int q = 7; q < NQ; q++) wr(q, 3, 1'b1, "R3 remap high");
        q_pend = 16'hFF88;
        for (int i = 0; i < 24; i++) step("R9 rotation");
        q_pend = 16'hA408;
        for (int i = 0; i < 10; i++) step("R9 sparse rotation");
        ch_busy = 8'h08;
        for (int i = 0; i < 3; i++) step("R9 R6 held by busy");
        ch_busy = '0;
        for (int i = 0; i < 5; i++) step("R9 resume");
        // R7: command channel above all
        q_pend = 16'hFFFF;
        wr(5, 7, 1'b1, "R3 map to command");
        wr(1, 7, 1'b1, "R3 map to command");
        for (int i = 0; i < 6; i++) step("R7 command first");
        ch_busy = 8'h80;
        for (int i = 0; i < 4; i++) step("R7 R6 command busy");
        ch_busy = 8'h88;
        for (int i = 0; i < 4; i++) step("R7 video next");
        ch_busy = '0;
        // R8/R10: mixed pending patterns
        for (int p = 0; p < 64; p++) begin
            q_pend = 16'((p * 16'h9E37) ^ (p << 3));
            step("R8 R10 mixed");
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule